// File: doc/BRIEF.md
# Write-Protected Calendar Clock Register Front End

This block sits between a simple register bus and the counting core of a calendar clock. It decodes a byte-offset address space: seven time fields that belong to the core, a control byte, a status byte, an interrupt-enable byte, an oscillator-control byte and a small bank of 32-bit scratch words. Time-field writes go to the core as a one-cycle strobe with a data byte. Time-field reads return the core's live values.

Every register except the two key registers is write-protected. Writes pass only while the first key register holds 0x83E70B13 and the second holds 0x95A4F1E0. Storing any other value in either key register, zero included, blocks writes again. While writes are blocked they are dropped without any error response.

The status byte has two sticky flags that software clears by writing 1 to them. One flag marks that the block came out of reset. The other records an alarm hit reported by the core. The remaining status bits show core flags as they are.

Top module: `rtc_kick_regif`

## Requirements
- R1: After reset the interface is locked (`unlocked` = 0). Control, interrupt-enable, oscillator and scratch registers read 0. Status bit 7 (power-up) reads 1 and status bit 6 (alarm) reads 0.
- R2: `unlocked` goes high only when both conditions hold: the register at 0x6C holds 0x83E70B13 and the register at 0x70 holds 0x95A4F1E0. With a wrong value in either register the interface stays locked.
- R3: While locked, writes to every register other than 0x6C and 0x70 are dropped. No time strobe fires and no stored value changes.
- R4: Writing 0, or any non-key value, to 0x6C or 0x70 locks the interface from the next cycle on.
- R5: While unlocked, a write to offset 4*k (k = 0 seconds … 6 weekday, offsets 0x00 to 0x18) raises `tm_wr_en` bit k alone in that same cycle, with `tm_wr_data` = wdata[7:0].
- R6: A read of time offset 4*k returns byte k of `tm_cur` (bits 8k+7:8k), zero-extended.
- R7: Control (0x40), interrupt enable (0x48) and oscillator (0x54) store wdata[7:0]. They read back zero-extended and drive `ctrl_out`, `irq_en_out` and `osc_out`.
- R8: Scratch words at 0x60, 0x64 and 0x68 store and return all 32 bits independently. Offset 0x6C is not scratch.
- R9: Status (0x44) reads {power-up, alarm, core_flags[5:0]}. Writing 1 to bit 7 or bit 6 clears that flag. Writing 0 leaves it unchanged. Bits 5:0 cannot be written.
- R10: An `alarm_hit` pulse sets the alarm flag. If it arrives in the same cycle as a clearing write, the flag stays set.
- R11: Reads of the key registers and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| unlocked | output | 1 | Writes to protected registers are accepted |
| tm_wr_en | output | 7 | One-hot time field write strobe |
| tm_wr_data | output | 8 | Byte for the strobed time field |
| tm_cur | input | 56 | Core's current time fields, byte k = field k |
| core_flags | input | 6 | Live core flags shown in status bits 5:0 |
| alarm_hit | input | 1 | Core alarm event pulse |
| ctrl_out | output | 8 | Control register value |
| irq_en_out | output | 8 | Interrupt enable value |
| osc_out | output | 8 | Oscillator control value |

## Verification
The bench writes only one key, then a wrong second key, to confirm that half an unlock opens nothing. A design that compared a single key, or latched the unlock on the first match, would accept the control write that follows. It clears each sticky flag with a 0 write and then with a 1 write. It also collides an alarm pulse with a clearing write, which exposes a clear that takes priority over the set or a mask applied to the wrong bit. Relocking with a zero key followed by a control write catches an unlock state that never drops. A read at 0x6C catches a scratch decode that runs one word too far.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int N_TIME = 7;
    localparam int FLAG_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_IRQ   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_OSC   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_SCR   = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_KEY_A = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_KEY_B = 8'h70;

    localparam logic [DATA_W-1:0] KEY_A_VAL = 32'h83E7_0B13;
    localparam logic [DATA_W-1:0] KEY_B_VAL = 32'h95A4_F1E0;

    localparam int ST_PWRUP = 7;
    localparam int ST_ALARM = 6;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic word_aligned(input logic [ADDR_W-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

    function automatic logic hits_time(input logic [ADDR_W-1:0] a);
        return word_aligned(a) && (int'(a) < N_TIME * 4);
    endfunction

    function automatic logic hits_scratch(input logic [ADDR_W-1:0] a, input int n);
        return word_aligned(a) && (int'(a) >= int'(OFS_SCR)) &&
               (int'(a) < int'(OFS_SCR) + 4 * n);
    endfunction

    function automatic logic is_key(input logic [ADDR_W-1:0] a);
        return (a == OFS_KEY_A) || (a == OFS_KEY_B);
    endfunction

endpackage

// File: rtl/rtcfe_kick.sv
module rtcfe_kick
    import rtcfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    unlocked
);

    logic [DATA_W-1:0] key_a_q;
    logic [DATA_W-1:0] key_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_a_q <= '0;
            key_b_q <= '0;
        end else if (wr.we) begin
            if (wr.addr == OFS_KEY_A) key_a_q <= wr.data;
            if (wr.addr == OFS_KEY_B) key_b_q <= wr.data;
        end
    end

    assign unlocked = (key_a_q == KEY_A_VAL) && (key_b_q == KEY_B_VAL);

    AST_UNLOCK_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(wr.we) && is_key($past(wr.addr)))); // R2

    AST_ZERO_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (wr.we && is_key(wr.addr) && wr.data == '0) |=> !unlocked); // R4

endmodule

// File: rtl/rtcfe_cfg.sv
module rtcfe_cfg
    import rtcfe_pkg::*;
#(
    parameter int N_SCRATCH = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_wr_t                       wr,
    input  logic                          unlocked,
    output logic [BYTE_W-1:0]             ctrl_q,
    output logic [BYTE_W-1:0]             irq_q,
    output logic [BYTE_W-1:0]             osc_q,
    output logic [N_SCRATCH*DATA_W-1:0]   scratch_flat
);

    logic wr_ok;
    assign wr_ok = wr.we && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            osc_q  <= '0;
        end else if (wr_ok) begin
            if (wr.addr == OFS_CTRL) ctrl_q <= wr.data[BYTE_W-1:0];
            if (wr.addr == OFS_IRQ)  irq_q  <= wr.data[BYTE_W-1:0];
            if (wr.addr == OFS_OSC)  osc_q  <= wr.data[BYTE_W-1:0];
        end
    end

    for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
        localparam logic [ADDR_W-1:0] MY_OFS = OFS_SCR + ADDR_W'(4 * i);
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)                             word_q <= '0;
            else if (wr_ok && wr.addr == MY_OFS) word_q <= wr.data;
        end
        assign scratch_flat[i*DATA_W +: DATA_W] = word_q;
    end

    AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(ctrl_q)); // R3

    AST_LOCKED_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(scratch_flat)); // R3

endmodule

// File: rtl/rtcfe_status.sv
module rtcfe_status
    import rtcfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    input  logic              unlocked,
    input  logic              alarm_hit,
    input  logic [FLAG_W-1:0] core_flags,
    output logic [BYTE_W-1:0] status
);

    logic pwrup_q;
    logic alarm_q;
    logic clr_hit;

    assign clr_hit = wr.we && unlocked && (wr.addr == OFS_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwrup_q <= 1'b1;
            alarm_q <= 1'b0;
        end else begin
            if (clr_hit && wr.data[ST_PWRUP]) pwrup_q <= 1'b0;
            if (alarm_hit)                    alarm_q <= 1'b1;
            else if (clr_hit && wr.data[ST_ALARM]) alarm_q <= 1'b0;
        end
    end

    assign status = {pwrup_q, alarm_q, core_flags};

    AST_PWRUP_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        !$rose(pwrup_q)); // R9

    AST_ALARM_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> alarm_q); // R10

    AST_LOCKED_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !alarm_hit) |=> $stable(status[ST_PWRUP:ST_ALARM])); // R3

endmodule

// File: rtl/rtc_kick_regif.sv
module rtc_kick_regif
    import rtcfe_pkg::*;
#(
    parameter int N_SCRATCH = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     unlocked,
    output logic [N_TIME-1:0]        tm_wr_en,
    output logic [BYTE_W-1:0]        tm_wr_data,
    input  logic [N_TIME*BYTE_W-1:0] tm_cur,
    input  logic [FLAG_W-1:0]        core_flags,
    input  logic                     alarm_hit,
    output logic [BYTE_W-1:0]        ctrl_out,
    output logic [BYTE_W-1:0]        irq_en_out,
    output logic [BYTE_W-1:0]        osc_out
);

    localparam int SCR_BITS = N_SCRATCH * DATA_W;

    bus_wr_t             wr;
    logic [BYTE_W-1:0]   status;
    logic [SCR_BITS-1:0] scratch_flat;

    assign wr = '{we: bus_we, addr: bus_addr, data: bus_wdata};

    rtcfe_kick u_kick (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .unlocked (unlocked)
    );

    rtcfe_cfg #(.N_SCRATCH(N_SCRATCH)) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .unlocked     (unlocked),
        .ctrl_q       (ctrl_out),
        .irq_q        (irq_en_out),
        .osc_q        (osc_out),
        .scratch_flat (scratch_flat)
    );

    rtcfe_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .unlocked   (unlocked),
        .alarm_hit  (alarm_hit),
        .core_flags (core_flags),
        .status     (status)
    );

    for (genvar k = 0; k < N_TIME; k++) begin : g_tstb
        assign tm_wr_en[k] = bus_we && unlocked && (bus_addr == ADDR_W'(4 * k));
    end
    assign tm_wr_data = bus_wdata[BYTE_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (hits_time(bus_addr)) begin
            bus_rdata[BYTE_W-1:0] = tm_cur[int'(bus_addr[ADDR_W-1:2])*BYTE_W +: BYTE_W];
        end else if (hits_scratch(bus_addr, N_SCRATCH)) begin
            bus_rdata = scratch_flat[(int'(bus_addr[ADDR_W-1:2]) - int'(OFS_SCR[ADDR_W-1:2]))*DATA_W +: DATA_W];
        end else begin
            unique case (bus_addr)
                OFS_CTRL: bus_rdata[BYTE_W-1:0] = ctrl_out;
                OFS_STAT: bus_rdata[BYTE_W-1:0] = status;
                OFS_IRQ:  bus_rdata[BYTE_W-1:0] = irq_en_out;
                OFS_OSC:  bus_rdata[BYTE_W-1:0] = osc_out;
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tm_wr_en)); // R5

    AST_STROBE_NEEDS_WE: assert property (@(posedge clk) disable iff (rst)
        (tm_wr_en != '0) |-> bus_we); // R5

endmodule

// File: tb/rtc_kick_regif_bench.sv
module rtc_kick_regif_bench;
    import rtcfe_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                     clk = 1'b0;
    logic                     rst;
    logic [ADDR_W-1:0]        bus_addr;
    logic [DATA_W-1:0]        bus_wdata;
    logic                     bus_we;
    logic [DATA_W-1:0]        bus_rdata;
    logic                     unlocked;
    logic [N_TIME-1:0]        tm_wr_en;
    logic [BYTE_W-1:0]        tm_wr_data;
    logic [N_TIME*BYTE_W-1:0] tm_cur;
    logic [FLAG_W-1:0]        core_flags;
    logic                     alarm_hit;
    logic [BYTE_W-1:0]        ctrl_out, irq_en_out, osc_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_kick_regif u_rtc_kick_regif (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .unlocked(unlocked),
        .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data), .tm_cur(tm_cur),
        .core_flags(core_flags), .alarm_hit(alarm_hit), .ctrl_out(ctrl_out),
        .irq_en_out(irq_en_out), .osc_out(osc_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 unlocked", {31'b0, unlocked}, 32'd0);
        bus_read(8'h40, d); chk("R1 ctrl", d, 32'h0);
        bus_read(8'h60, d); chk("R1 scratch", d, 32'h0);
        bus_read(8'h44, d); chk("R1 status", d, 32'h95);
    endtask

    task automatic t_locked_drop();
        logic [31:0] d;
        bus_write(8'h40, 32'hAB);
        bus_read(8'h40, d); chk("R3 ctrl dropped", d, 32'h0);
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h11; bus_we = 1'b1;
        #1 chk("R3 no strobe", {25'b0, tm_wr_en}, 32'h0);
        @(negedge clk); bus_we = 1'b0;
        bus_write(8'h44, 32'hC0);
        bus_read(8'h44, d); chk("R3 status kept", d, 32'h95);
    endtask

    task automatic t_unlock();
        bus_write(8'h6C, KEY_A_VAL);
        chk("R2 one key", {31'b0, unlocked}, 32'd0);
        bus_write(8'h70, 32'h1234);
        chk("R2 wrong key", {31'b0, unlocked}, 32'd0);
        bus_write(8'h70, KEY_B_VAL);
        chk("R2 both keys", {31'b0, unlocked}, 32'd1);
    endtask

    task automatic t_time();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h123; bus_we = 1'b1;
        #1 chk("R5 hours strobe", {25'b0, tm_wr_en}, 32'h04);
        chk("R5 data", {24'b0, tm_wr_data}, 32'h23);
        bus_addr = 8'h18;
        #1 chk("R5 weekday strobe", {25'b0, tm_wr_en}, 32'h40);
        @(negedge clk); bus_we = 1'b0;
        tm_cur = 56'h06_25_12_31_23_59_58;
        bus_read(8'h0C, d); chk("R6 days read", d, 32'h31);
        bus_read(8'h00, d); chk("R6 seconds read", d, 32'h58);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_write(8'h40, 32'hFF81);
        bus_read(8'h40, d); chk("R7 ctrl read", d, 32'h81);
        chk("R7 ctrl out", {24'b0, ctrl_out}, 32'h81);
        bus_write(8'h48, 32'h5A);
        chk("R7 irq out", {24'b0, irq_en_out}, 32'h5A);
        bus_write(8'h54, 32'h48);
        bus_read(8'h54, d); chk("R7 osc read", d, 32'h48);
        chk("R7 osc out", {24'b0, osc_out}, 32'h48);
    endtask

    task automatic t_scratch();
        logic [31:0] d;
        bus_write(8'h64, 32'hDEADBEEF);
        bus_write(8'h68, 32'h0BADF00D);
        bus_read(8'h64, d); chk("R8 scratch1", d, 32'hDEADBEEF);
        bus_read(8'h68, d); chk("R8 scratch2", d, 32'h0BADF00D);
        bus_read(8'h60, d); chk("R8 scratch0", d, 32'h0);
        bus_read(8'h6C, d); chk("R8 R11 key not scratch", d, 32'h0);
        chk("R8 still unlocked", {31'b0, unlocked}, 32'd1);
    endtask

    task automatic t_status();
        logic [31:0] d;
        bus_write(8'h44, 32'h3F);
        bus_read(8'h44, d); chk("R9 zero write", d, 32'h95);
        @(negedge clk); alarm_hit = 1'b1;
        @(negedge clk); alarm_hit = 1'b0;
        bus_read(8'h44, d); chk("R10 alarm set", d, 32'hD5);
        bus_write(8'h44, 32'h40);
        bus_read(8'h44, d); chk("R9 alarm clear", d, 32'h95);
        bus_write(8'h44, 32'h80);
        bus_read(8'h44, d); chk("R9 pwrup clear", d, 32'h15);
        @(negedge clk);
        bus_addr = 8'h44; bus_wdata = 32'h40; bus_we = 1'b1; alarm_hit = 1'b1;
        @(negedge clk); bus_we = 1'b0; alarm_hit = 1'b0;
        bus_read(8'h44, d); chk("R10 set wins", d, 32'h55);
    endtask

    task automatic t_relock();
        logic [31:0] d;
        bus_write(8'h70, 32'h0);
        chk("R4 relocked", {31'b0, unlocked}, 32'd0);
        bus_write(8'h40, 32'h00);
        bus_read(8'h40, d); chk("R4 ctrl kept", d, 32'h81);
        bus_read(8'h30, d); chk("R11 unmapped", d, 32'h0);
        bus_read(8'h70, d); chk("R11 key read", d, 32'h0);
    endtask

    initial begin
        fork
            begin
                rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
                tm_cur = '0; core_flags = 6'h15; alarm_hit = 1'b0;
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_locked_drop();
                t_unlock();
                t_time();
                t_regs();
                t_scratch();
                t_status();
                t_relock();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog got timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule